// File: doc/BRIEF.md
# Outstanding Line-Miss Tracker

This block sits beside a non-blocking data cache and keeps one record for each memory line being fetched. When a load misses, the tracker looks for a record of that same line. If it finds one, the load joins it. If it does not, it claims a free record and sends one line request to memory, tagged with the record's index. Each record keeps, for every word of the line, the destination register that waits for that word. Accepted loads leave the pipeline at once.

A per-register full/empty scoreboard is part of the block. An accepted load clears its destination's bit to Empty. The decode stage asks through a query port whether a source register is still Empty, and stalls while it is. Memory responses carry the record index, so lines may return in any order.

Once a line is back, the record sends its waiting words to the register file one per cycle, lowest word first. Each register turns Full as its word goes out. The record becomes free in the same cycle as its last writeback.

Top module: `mshr_table`

## Requirements
- R1: After reset every register reads not busy, no writeback is offered, no line request is issued, and every record is free.
- R2: A miss to a line with no pending record is accepted when a record is free. It claims the lowest-numbered free record, and in the next cycle req_valid_o pulses for one cycle with the line address and that record index.
- R3: A miss to a line whose record is still waiting for memory is accepted with no new line request, even when every record is in use.
- R4: The destination register of an accepted miss reads busy on the query port from the cycle after acceptance.
- R5: A miss to a word that already has a waiting register in the matching pending record is rejected. The recorded register is unchanged, and the rejected load's register is never marked busy.
- R6: With all 4 records in use, a miss to a line that none of them tracks is rejected.
- R7: Starting the cycle after a fill for a pending record, that record's waiting words come out one per cycle in ascending word order. Each carries its recorded register and the data of word w, taken from fill_data_i bits [w*32 +: 32].
- R8: A register reads not busy from the cycle after its writeback.
- R9: A record is free again from the cycle after its last writeback, and a new line can claim it.
- R10: Fills may arrive in any order of record index. Each drains only its own record.
- R11: A miss whose destination register is already busy is rejected.
- R12: A miss to a line whose record has returned but is still draining is rejected.
- R13: A fill naming a record that is not pending is ignored and causes no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| miss_valid_i | input | 1 | A load miss is presented |
| miss_line_i | input | LINE_W | Line address of the miss |
| miss_word_i | input | log2(WORDS) | Word within the line |
| miss_reg_i | input | log2(NUM_REGS) | Destination register of the load |
| miss_accept_o | output | 1 | Miss taken this cycle; low means the load stalls |
| req_valid_o | output | 1 | Line request to memory |
| req_line_o | output | LINE_W | Requested line address |
| req_id_o | output | log2(ENTRIES) | Record index carried by the request |
| fill_valid_i | input | 1 | Line returned from memory |
| fill_id_i | input | log2(ENTRIES) | Record index of the returned line |
| fill_data_i | input | WORDS*DATA_W | Line data, word w at bits [w*DATA_W +: DATA_W] |
| wb_valid_o | output | 1 | A word is being written to a register |
| wb_reg_o | output | log2(NUM_REGS) | Register being written |
| wb_data_o | output | DATA_W | Data being written |
| query_reg_i | input | log2(NUM_REGS) | Source register asked about by decode |
| query_busy_o | output | 1 | Queried register is Empty |

## Verification
miss_accept_o depends only on the current inputs and state, so the bench reads it one time unit after driving the miss, before the edge that commits it. req_valid_o and the busy bit of the destination change at the accepting edge. The first writeback is offered in the cycle after the fill edge, and each further word follows one edge later. The bench therefore samples one time unit after each rising edge and checks exactly one writeback per cycle. A register's busy bit and the freeing of a record are checked one edge after the writeback that causes them.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_FILL = 2'd2
  } ent_state_e;
endpackage

// File: rtl/mshr_prio.sv
// lowest-index-wins priority picker
module mshr_prio #(
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_empty_i,
  input  logic [REG_W-1:0]    empty_reg_i,
  input  logic                set_full_i,
  input  logic [REG_W-1:0]    full_reg_i,
  output logic [NUM_REGS-1:0] empty_o
);
  logic [NUM_REGS-1:0] empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= '0;
    end else begin
      if (set_full_i)  empty_q[full_reg_i]  <= 1'b0;
      if (set_empty_i) empty_q[empty_reg_i] <= 1'b1;
    end
  end

  assign empty_o = empty_q;
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry import mshr_pkg::*; #(
  parameter int LINE_W = 26,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int WIDX_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    add_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [WIDX_W-1:0]       word_i,
  input  logic [REG_W-1:0]        reg_i,
  input  logic                    fill_i,
  input  logic [WORDS*DATA_W-1:0] fill_data_i,
  input  logic                    wb_clr_i,
  input  logic [WIDX_W-1:0]       wb_word_i,
  output logic                    pend_o,
  output logic                    filled_o,
  output logic [LINE_W-1:0]       line_o,
  output logic [WORDS-1:0]        wait_o,
  output logic [WORDS*REG_W-1:0]  tags_o,
  output logic [WORDS*DATA_W-1:0] data_o
);
  ent_state_e              state_q, state_d;
  logic [WORDS-1:0]        wait_q, wait_d;
  logic [LINE_W-1:0]       line_q;
  logic [REG_W-1:0]        tag_q [WORDS];
  logic [WORDS*DATA_W-1:0] data_q;
  logic                    take_fill;

  assign take_fill = fill_i && (state_q == ST_PEND);

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    if (alloc_i) begin
      state_d         = ST_PEND;
      wait_d          = '0;
      wait_d[word_i]  = 1'b1;
    end else begin
      if (add_i)     wait_d[word_i] = 1'b1;
      if (take_fill) state_d = ST_FILL;
      if (wb_clr_i) begin
        wait_d[wb_word_i] = 1'b0;
        if (wait_d == '0) state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      line_q  <= '0;
      data_q  <= '0;
      for (int w = 0; w < WORDS; w++) tag_q[w] <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      if (alloc_i) line_q <= line_i;
      if (alloc_i || add_i) tag_q[word_i] <= reg_i;
      if (take_fill) data_q <= fill_data_i;
    end
  end

  assign pend_o   = (state_q == ST_PEND);
  assign filled_o = (state_q == ST_FILL);
  assign line_o   = line_q;
  assign wait_o   = wait_q;
  assign data_o   = data_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_tag
    assign tags_o[w*REG_W +: REG_W] = tag_q[w];
  end
endmodule

// File: rtl/mshr_table.sv
module mshr_table #(
  parameter int LINE_W   = 26,
  parameter int WORDS    = 4,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int ENTRIES  = 4,
  parameter int ID_W     = $clog2(ENTRIES),
  parameter int WIDX_W   = $clog2(WORDS),
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  input  logic [LINE_W-1:0]       miss_line_i,
  input  logic [WIDX_W-1:0]       miss_word_i,
  input  logic [REG_W-1:0]        miss_reg_i,
  output logic                    miss_accept_o,
  output logic                    req_valid_o,
  output logic [LINE_W-1:0]       req_line_o,
  output logic [ID_W-1:0]         req_id_o,
  input  logic                    fill_valid_i,
  input  logic [ID_W-1:0]         fill_id_i,
  input  logic [WORDS*DATA_W-1:0] fill_data_i,
  output logic                    wb_valid_o,
  output logic [REG_W-1:0]        wb_reg_o,
  output logic [DATA_W-1:0]       wb_data_o,
  input  logic [REG_W-1:0]        query_reg_i,
  output logic                    query_busy_o
);
  localparam int SLOTS = ENTRIES * WORDS;
  localparam int SLOT_W = ID_W + WIDX_W;

  logic [ENTRIES-1:0]              ent_pend, ent_filled, ent_busy, ent_free;
  logic [ENTRIES-1:0]              hit_pend, hit_fill;
  logic [ENTRIES*LINE_W-1:0]       line_all;
  logic [SLOTS-1:0]                wait_all, ready_all;
  logic [SLOTS*REG_W-1:0]          tags_all;
  logic [ENTRIES*WORDS*DATA_W-1:0] data_all;
  logic [NUM_REGS-1:0]             sb_empty;

  logic              any_hit, any_free, wb_any;
  logic [ID_W-1:0]   hit_idx, free_idx, tgt;
  logic [SLOT_W-1:0] wb_slot, tgt_slot;
  logic [ID_W-1:0]   wb_entry;
  logic [WIDX_W-1:0] wb_word;
  logic              do_alloc, do_merge, accept;

  // per-record state
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    mshr_entry #(
      .LINE_W(LINE_W), .WORDS(WORDS), .DATA_W(DATA_W), .REG_W(REG_W)
    ) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (do_alloc && (tgt == ID_W'(e))),
      .add_i       (do_merge && (tgt == ID_W'(e))),
      .line_i      (miss_line_i),
      .word_i      (miss_word_i),
      .reg_i       (miss_reg_i),
      .fill_i      (fill_valid_i && (fill_id_i == ID_W'(e))),
      .fill_data_i (fill_data_i),
      .wb_clr_i    (wb_any && (wb_entry == ID_W'(e))),
      .wb_word_i   (wb_word),
      .pend_o      (ent_pend[e]),
      .filled_o    (ent_filled[e]),
      .line_o      (line_all[e*LINE_W +: LINE_W]),
      .wait_o      (wait_all[e*WORDS +: WORDS]),
      .tags_o      (tags_all[e*WORDS*REG_W +: WORDS*REG_W]),
      .data_o      (data_all[e*WORDS*DATA_W +: WORDS*DATA_W])
    );

    assign ent_busy[e] = ent_pend[e] | ent_filled[e];
    assign ent_free[e] = ~ent_busy[e];
    assign hit_pend[e] = ent_pend[e]   && (line_all[e*LINE_W +: LINE_W] == miss_line_i);
    assign hit_fill[e] = ent_filled[e] && (line_all[e*LINE_W +: LINE_W] == miss_line_i);
    assign ready_all[e*WORDS +: WORDS] = ent_filled[e] ? wait_all[e*WORDS +: WORDS] : '0;
  end

  mshr_prio #(.N(ENTRIES)) u_hit_pick (
    .req_i (hit_pend), .any_o (any_hit), .idx_o (hit_idx)
  );

  mshr_prio #(.N(ENTRIES)) u_free_pick (
    .req_i (ent_free), .any_o (any_free), .idx_o (free_idx)
  );

  // lowest record first, then lowest word inside it
  mshr_prio #(.N(SLOTS)) u_wb_pick (
    .req_i (ready_all), .any_o (wb_any), .idx_o (wb_slot)
  );

  assign wb_entry = wb_slot[WIDX_W +: ID_W];
  assign wb_word  = wb_slot[WIDX_W-1:0];

  // miss decision
  always_comb begin
    do_alloc = 1'b0;
    do_merge = 1'b0;
    accept   = 1'b0;
    tgt      = any_hit ? hit_idx : free_idx;
    tgt_slot = {tgt, miss_word_i};
    if (miss_valid_i && !sb_empty[miss_reg_i]) begin
      if (any_hit) begin
        if (!wait_all[tgt_slot]) begin
          do_merge = 1'b1;
          accept   = 1'b1;
        end
      end else if (!(|hit_fill) && any_free) begin
        do_alloc = 1'b1;
        accept   = 1'b1;
      end
    end
  end

  assign miss_accept_o = accept;

  mshr_scoreboard #(.NUM_REGS(NUM_REGS)) u_sb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_empty_i (accept),
    .empty_reg_i (miss_reg_i),
    .set_full_i  (wb_any),
    .full_reg_i  (wb_reg_o),
    .empty_o     (sb_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_o <= 1'b0;
      req_line_o  <= '0;
      req_id_o    <= '0;
    end else begin
      req_valid_o <= do_alloc;
      if (do_alloc) begin
        req_line_o <= miss_line_i;
        req_id_o   <= tgt;
      end
    end
  end

  assign wb_valid_o   = wb_any;
  assign wb_reg_o     = tags_all[wb_slot*REG_W +: REG_W];
  assign wb_data_o    = data_all[wb_slot*DATA_W +: DATA_W];
  assign query_busy_o = sb_empty[query_reg_i];
endmodule

// File: rtl/mshr_table_chk.sv
module mshr_table_chk #(
  parameter int NUM_REGS = 32,
  parameter int ENTRIES  = 4,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                miss_valid_i,
  input logic [REG_W-1:0]    miss_reg_i,
  input logic                miss_accept_o,
  input logic                req_valid_o,
  input logic                wb_valid_o,
  input logic [REG_W-1:0]    wb_reg_o,
  input logic [NUM_REGS-1:0] sb_empty,
  input logic [ENTRIES-1:0]  ent_busy,
  input logic [ENTRIES-1:0]  hit_pend
);
  p_req_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> $past(miss_valid_i && miss_accept_o));

  p_mark_empty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_accept_o) |=> sb_empty[$past(miss_reg_i)]);

  p_full_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && (&ent_busy) && !(|hit_pend)) |-> !miss_accept_o);

  p_wb_to_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> sb_empty[wb_reg_o]);

  p_wb_sets_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !sb_empty[$past(wb_reg_o)]);

  p_busy_dest_stall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && sb_empty[miss_reg_i]) |-> !miss_accept_o);
endmodule

bind mshr_table mshr_table_chk #(
  .NUM_REGS(NUM_REGS), .ENTRIES(ENTRIES), .REG_W(REG_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .miss_valid_i  (miss_valid_i),
  .miss_reg_i    (miss_reg_i),
  .miss_accept_o (miss_accept_o),
  .req_valid_o   (req_valid_o),
  .wb_valid_o    (wb_valid_o),
  .wb_reg_o      (wb_reg_o),
  .sb_empty      (sb_empty),
  .ent_busy      (ent_busy),
  .hit_pend      (hit_pend)
);

// File: tb/mshr_table_test.sv
module mshr_table_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         miss_valid_i = 1'b0;
  logic [25:0]  miss_line_i = '0;
  logic [1:0]   miss_word_i = '0;
  logic [4:0]   miss_reg_i = '0;
  logic         miss_accept_o;
  logic         req_valid_o;
  logic [25:0]  req_line_o;
  logic [1:0]   req_id_o;
  logic         fill_valid_i = 1'b0;
  logic [1:0]   fill_id_i = '0;
  logic [127:0] fill_data_i = '0;
  logic         wb_valid_o;
  logic [4:0]   wb_reg_o;
  logic [31:0]  wb_data_o;
  logic [4:0]   query_reg_i = '0;
  logic         query_busy_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  mshr_table uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic busy_is(input string req, input logic [4:0] r, input logic exp);
    query_reg_i = r;
    #1;
    check(req, query_busy_o, exp);
  endtask

  // drive one miss; ends 1 unit after the commit edge
  task automatic miss(input string req, input logic [25:0] line, input logic [1:0] word,
                      input logic [4:0] r, input logic exp_acc, input logic exp_req,
                      input logic [1:0] exp_id);
    @(negedge clk_i);
    miss_valid_i = 1'b1;
    miss_line_i  = line;
    miss_word_i  = word;
    miss_reg_i   = r;
    #1;
    check(req, miss_accept_o, exp_acc);
    @(posedge clk_i);
    #1;
    miss_valid_i = 1'b0;
    check(req, req_valid_o, exp_req);
    if (exp_req) begin
      check(req, req_line_o, line);
      check(req, req_id_o, exp_id);
    end
  endtask

  task automatic fill(input logic [1:0] id, input logic [31:0] base);
    @(negedge clk_i);
    fill_valid_i = 1'b1;
    fill_id_i    = id;
    for (int w = 0; w < 4; w++) fill_data_i[w*32 +: 32] = base + 32'(w);
    @(posedge clk_i);
    #1;
    fill_valid_i = 1'b0;
  endtask

  // current cycle must show this writeback; ends 1 unit after the next edge
  task automatic expect_wb(input string req, input logic [4:0] r, input logic [1:0] word,
                           input logic [31:0] base);
    check(req, wb_valid_o, 1'b1);
    check(req, wb_reg_o, r);
    check(req, wb_data_o, base + 32'(word));
    @(posedge clk_i);
    #1;
    busy_is("R8", r, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", wb_valid_o, 1'b0);
    check("R1", req_valid_o, 1'b0);
    for (int r = 0; r < 32; r += 7) busy_is("R1", 5'(r), 1'b0);
  endtask

  task automatic t_alloc_merge();
    miss("R2", 26'h100, 2'd1, 5'd5, 1'b1, 1'b1, 2'd0);
    busy_is("R4", 5'd5, 1'b1);
    miss("R3", 26'h100, 2'd3, 5'd7, 1'b1, 1'b0, 2'd0);
    busy_is("R4", 5'd7, 1'b1);
    miss("R5", 26'h100, 2'd1, 5'd9, 1'b0, 1'b0, 2'd0);
    busy_is("R5", 5'd9, 1'b0);
    miss("R11", 26'h180, 2'd0, 5'd5, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic t_drain();
    fill(2'd0, 32'h1000);
    // line is draining: new miss to it must stall (r12_)
    miss_valid_i = 1'b1;
    miss_line_i  = 26'h100;
    miss_word_i  = 2'd0;
    miss_reg_i   = 5'd12;
    #1;
    check("R12", miss_accept_o, 1'b0);
    miss_valid_i = 1'b0;
    #1;
    expect_wb("R7", 5'd5, 2'd1, 32'h1000);
    expect_wb("R7", 5'd7, 2'd3, 32'h1000);
    check("R7", wb_valid_o, 1'b0);
    busy_is("R5", 5'd9, 1'b0);
  endtask

  task automatic t_full_ooo();
    miss("R9", 26'h200, 2'd0, 5'd1, 1'b1, 1'b1, 2'd0);
    miss("R2", 26'h201, 2'd0, 5'd2, 1'b1, 1'b1, 2'd1);
    miss("R2", 26'h202, 2'd0, 5'd3, 1'b1, 1'b1, 2'd2);
    miss("R2", 26'h203, 2'd0, 5'd4, 1'b1, 1'b1, 2'd3);
    miss("R6", 26'h204, 2'd0, 5'd6, 1'b0, 1'b0, 2'd0);
    busy_is("R6", 5'd6, 1'b0);
    miss("R3", 26'h202, 2'd2, 5'd8, 1'b1, 1'b0, 2'd0);
    fill(2'd2, 32'h2000);
    expect_wb("R10", 5'd3, 2'd0, 32'h2000);
    expect_wb("R10", 5'd8, 2'd2, 32'h2000);
    check("R10", wb_valid_o, 1'b0);
    miss("R9", 26'h204, 2'd1, 5'd6, 1'b1, 1'b1, 2'd2);
    fill(2'd3, 32'h3000);
    expect_wb("R10", 5'd4, 2'd0, 32'h3000);
    check("R10", wb_valid_o, 1'b0);
    busy_is("R10", 5'd1, 1'b1);
    fill(2'd0, 32'h4000);
    expect_wb("R10", 5'd1, 2'd0, 32'h4000);
    fill(2'd1, 32'h5000);
    expect_wb("R10", 5'd2, 2'd0, 32'h5000);
    fill(2'd2, 32'h6000);
    expect_wb("R10", 5'd6, 2'd1, 32'h6000);
    check("R10", wb_valid_o, 1'b0);
  endtask

  task automatic t_stray_fill();
    fill(2'd1, 32'h7000);
    check("R13", wb_valid_o, 1'b0);
    @(posedge clk_i);
    #1;
    check("R13", wb_valid_o, 1'b0);
    miss("R13", 26'h300, 2'd2, 5'd10, 1'b1, 1'b1, 2'd0);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    t_alloc_merge();
    t_drain();
    t_full_ooo();
    t_stray_fill();
    summary();
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL all: watchdog expired, actual running expected done");
    summary();
  end
endmodule